// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits in front of one shared word-addressed memory and serves several processor ports. Each port can issue a plain load, a plain store, a load-reserved or a store-conditional. The block holds one reservation per port, made of a valid flag and a word address. A load-reserved returns the memory word and arms that reservation. A store-conditional writes memory only while the issuing port still holds a reservation on exactly that address. A successful conditional write removes any reservation that other ports hold on the same word, so at most one of several competing read-modify-write sequences can commit.

Requests enter on a per-port valid/ready handshake. A round-robin arbiter accepts at most one request per cycle. Accepting requests one at a time is what makes the reservation check and the memory update atomic. A requester keeps `req_valid` high, with stable op, address and data, until it sees `req_ready` high in the same cycle. A port is back-pressured whenever another port holds the grant. The response comes one cycle after acceptance as a one-cycle `rsp_valid` pulse on the port's own bit. The response path has no back-pressure, so the requester must take it in that cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset every reservation is cleared, every memory word reads zero, `rsp_valid` is low, and `req_ready` is low while no request is valid.
- R2: A load (op 2'd0) accepted in cycle T gives, in cycle T+1, `rsp_valid` high only on the issuing port's bit, `rsp_data` equal to the addressed word, and `rsp_ok`=1.
- R3: A store (op 2'd1) writes `req_wdata` to the addressed word and responds with `rsp_ok`=1 and `rsp_data`=0. A later load returns the stored word.
- R4: A load-reserved (op 2'd2) returns the addressed word with `rsp_ok`=1 and arms the port's reservation on that address. A newer load-reserved from the same port replaces the older reservation.
- R5: A store-conditional (op 2'd3) whose port holds a reservation on the same address writes memory and responds with `rsp_ok`=1 and `rsp_data`=0.
- R6: A store-conditional with no reservation, or with a reservation on a different address, leaves memory unchanged and responds with `rsp_ok`=0.
- R7: Every store-conditional clears the issuing port's reservation, whether it passes or fails.
- R8: A passing store-conditional clears every other port's reservation on the same address. Reservations on other addresses are kept.
- R9: A plain store clears all reservations on its address, including the storing port's own reservation.
- R10: At most one request is accepted per cycle. While several ports keep requesting, grants rotate in ascending port order with wrap-around, starting after the port served last.
- R11: `req_ready` is high only for the granted port. A request that is not granted is neither performed nor answered until a later cycle grants it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_ready | output | NPORT | Request accepted this cycle, one bit per port |
| req_op | input | 2*NPORT | Per-port op: 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr | input | AW*NPORT | Per-port word address |
| req_wdata | input | DW*NPORT | Per-port store data |
| rsp_valid | output | NPORT | One-cycle response pulse on the served port's bit |
| rsp_data | output | DW | Loaded word; zero for stores |
| rsp_ok | output | 1 | 1 on success; for store-conditional, pass/fail |

## Verification
The hardest situation to reach from the ports is a race: two or more ports hold live reservations on one word, and one of them then commits. The bench then has to show that the competitors fail while reservations on neighbouring words survive. Directed sequences build this case explicitly. A long random run then confines addresses to four words across four ports, so reservations collide, get overwritten and get cancelled by plain stores very often. Every response is compared with a bench-side model of memory and reservations.

// File: rtl/lrsc_pkg.sv
`timescale 1ns/1ps
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LRES  = 2'd2,
    OP_SCOND = 2'd3
  } mem_op_e;
endpackage

// File: rtl/lrsc_rr_arb.sv
`timescale 1ns/1ps
module lrsc_rr_arb #(
  parameter int NPORT = 4,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  output logic [NPORT-1:0] grant,
  output logic [IW-1:0]    grant_idx
);
  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 1; k <= NPORT; k++) begin
      int j;
      j = (int'(last_q) + k) % NPORT;
      if (!found && req[j]) begin
        grant[j]  = 1'b1;
        grant_idx = IW'(j);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= IW'(NPORT - 1);
    else if (found)  last_q <= grant_idx;
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/lrsc_mem_bank.sv
`timescale 1ns/1ps
module lrsc_mem_bank #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words_q [DEPTH];

  assign rdata = words_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (we) begin
      words_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/lrsc_resv_table.sv
`timescale 1ns/1ps
module lrsc_resv_table
  import lrsc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW = 6,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] port,
  input  mem_op_e       op,
  input  logic [AW-1:0] addr,
  output logic          sc_pass
);
  logic [NPORT-1:0] armed_q;
  logic [AW-1:0]    where_q [NPORT];
  logic [NPORT-1:0] hit;

  always_comb begin
    for (int i = 0; i < NPORT; i++) hit[i] = armed_q[i] && (where_q[i] == addr);
  end

  assign sc_pass = hit[port];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= '0;
      for (int i = 0; i < NPORT; i++) where_q[i] <= '0;
    end else if (fire) begin
      for (int i = 0; i < NPORT; i++) begin
        unique case (op)
          OP_LRES: if (IW'(i) == port) begin
            armed_q[i] <= 1'b1;
            where_q[i] <= addr;
          end
          OP_STORE: if (hit[i]) armed_q[i] <= 1'b0;
          OP_SCOND: begin
            if (IW'(i) == port) armed_q[i] <= 1'b0;
            else if (sc_pass && hit[i]) armed_q[i] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // checker support: hits on the previous cycle's address
  logic [AW-1:0]    chk_addr_q;
  logic [NPORT-1:0] chk_hit;
  always_ff @(posedge clk) chk_addr_q <= addr;
  always_comb begin
    for (int i = 0; i < NPORT; i++) chk_hit[i] = armed_q[i] && (where_q[i] == chk_addr_q);
  end

  // R4
  lr_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_LRES) |=> (armed_q[$past(port)] && where_q[$past(port)] == $past(addr)));

  // R7
  sc_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SCOND) |=> !armed_q[$past(port)]);

  // R8
  sc_win_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SCOND && sc_pass) |=> (chk_hit == '0));

  // R9
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_STORE) |=> (chk_hit == '0));
endmodule

// File: rtl/lrsc_monitor.sv
`timescale 1ns/1ps
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  output logic [NPORT-1:0]    req_ready,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [AW*NPORT-1:0] req_addr,
  input  logic [DW*NPORT-1:0] req_wdata,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                rsp_ok
);
  logic [NPORT-1:0] grant;
  logic [IW-1:0]    gidx;
  logic             fire;
  mem_op_e          sel_op;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic [DW-1:0]    rd_word;
  logic             sc_pass;
  logic             mem_we;

  lrsc_rr_arb #(.NPORT(NPORT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .grant(grant), .grant_idx(gidx)
  );

  assign fire      = |grant;
  assign req_ready = grant;
  assign sel_op    = mem_op_e'(req_op[gidx*2 +: 2]);
  assign sel_addr  = req_addr[gidx*AW +: AW];
  assign sel_wdata = req_wdata[gidx*DW +: DW];

  lrsc_resv_table #(.NPORT(NPORT), .AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_n), .fire(fire), .port(gidx), .op(sel_op),
    .addr(sel_addr), .sc_pass(sc_pass)
  );

  assign mem_we = fire && ((sel_op == OP_STORE) || (sel_op == OP_SCOND && sc_pass));

  lrsc_mem_bank #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(sel_addr),
    .wdata(sel_wdata), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= grant;
      rsp_data  <= (fire && (sel_op == OP_LOAD || sel_op == OP_LRES)) ? rd_word : '0;
      rsp_ok    <= fire && ((sel_op != OP_SCOND) || sc_pass);
    end
  end

  // R10
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  // R6
  sc_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_SCOND && !sc_pass) |-> !mem_we);
endmodule

// File: tb/test_lrsc_monitor.sv
`timescale 1ns/1ps
module test_lrsc_monitor;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;

  lrsc_monitor #(.NPORT(N), .AW(AW), .DW(DW)) i_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [1<<AW];
  bit            m_arm [N];
  logic [AW-1:0] m_at  [N];

  task automatic check(bit cond, string req, longint act, longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                       output logic [DW-1:0] ed, output bit eok, output string tag);
    bit pass;
    ed = '0; eok = 1'b1;
    case (op)
      2'd0: begin ed = m_mem[a]; tag = "R2"; end
      2'd1: begin
        m_mem[a] = d; tag = "R3/R9";
        for (int i = 0; i < N; i++) if (m_arm[i] && m_at[i] == a) m_arm[i] = 1'b0;
      end
      2'd2: begin ed = m_mem[a]; m_arm[p] = 1'b1; m_at[p] = a; tag = "R4"; end
      default: begin
        pass = m_arm[p] && m_at[p] == a;
        eok = pass;
        tag = pass ? "R5/R8" : "R6/R7";
        m_arm[p] = 1'b0;
        if (pass) begin
          m_mem[a] = d;
          for (int i = 0; i < N; i++) if (m_arm[i] && m_at[i] == a) m_arm[i] = 1'b0;
        end
      end
    endcase
  endtask

  task automatic drive(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    req_op[p*2 +: 2]     = op;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
    req_valid[p]         = 1'b1;
  endtask

  task automatic do_req(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] ed; bit eok; string tag;
    model(p, op, a, d, ed, eok, tag);
    drive(p, op, a, d);
    #1;
    check(req_ready == (N'(1) << p), "R11 ready", req_ready, N'(1) << p);
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    check(rsp_valid == (N'(1) << p), {tag, " rsp_valid"}, rsp_valid, N'(1) << p);
    check(rsp_data == ed, {tag, " rsp_data"}, rsp_data, ed);
    check(rsp_ok == eok, {tag, " rsp_ok"}, rsp_ok, eok);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
    for (int i = 0; i < N; i++) begin m_arm[i] = 1'b0; m_at[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(rsp_valid == '0, "R1 rsp_valid", rsp_valid, 0);
    check(req_ready == '0, "R1 req_ready", req_ready, 0);
    do_req(0, 2'd0, 6'd5, '0);          // R1 memory zero
    do_req(1, 2'd3, 6'd5, 32'h77);      // R1 no reservation -> fail
    do_req(2, 2'd0, 6'd5, '0);

    // R2 R3
    do_req(1, 2'd1, 6'd3, 32'hAAAA_5555);
    do_req(2, 2'd0, 6'd3, '0);
    // R4 R5
    do_req(0, 2'd2, 6'd3, '0);
    do_req(0, 2'd3, 6'd3, 32'h1111);
    do_req(3, 2'd0, 6'd3, '0);
    // R7 R6
    do_req(0, 2'd3, 6'd3, 32'h2222);
    do_req(1, 2'd3, 6'd9, 32'h3333);
    do_req(1, 2'd0, 6'd9, '0);
    // R4 replacement, R6 address mismatch
    do_req(0, 2'd2, 6'd4, '0);
    do_req(0, 2'd2, 6'd7, '0);
    do_req(0, 2'd3, 6'd4, 32'h4444);
    do_req(0, 2'd0, 6'd4, '0);
    // R8 race
    do_req(1, 2'd2, 6'd10, '0);
    do_req(2, 2'd2, 6'd10, '0);
    do_req(3, 2'd2, 6'd11, '0);
    do_req(1, 2'd3, 6'd10, 32'hB0B0);
    do_req(2, 2'd3, 6'd10, 32'hC0C0);
    do_req(3, 2'd3, 6'd11, 32'hD0D0);
    do_req(0, 2'd0, 6'd10, '0);
    // R9 plain store clears own and others
    do_req(0, 2'd2, 6'd12, '0);
    do_req(1, 2'd2, 6'd12, '0);
    do_req(0, 2'd1, 6'd12, 32'hE0E0);
    do_req(0, 2'd3, 6'd12, 32'hF0F0);
    do_req(1, 2'd3, 6'd12, 32'hF1F1);

    // R10 R11: all ports request at once
    begin
      int prev = -1;
      bit [N-1:0] served = '0;
      for (int i = 0; i < N; i++) drive(i, 2'd0, AW'(i), '0);
      for (int c = 0; c < N; c++) begin
        int g = -1;
        #1;
        check($countones(req_ready) == 1, "R10 one accept", req_ready, 1);
        for (int i = 0; i < N; i++) if (req_ready[i]) g = i;
        if (prev >= 0) check(g == (prev + 1) % N, "R10 rotation", g, (prev + 1) % N);
        @(posedge clk);
        @(negedge clk);
        if (g >= 0) begin
          req_valid[g] = 1'b0;
          served[g] = 1'b1;
          check(rsp_valid == (N'(1) << g), "R11 rsp port", rsp_valid, N'(1) << g);
          check(rsp_data == m_mem[g], "R2 rsp_data arb", rsp_data, m_mem[g]);
        end
        prev = g;
      end
      check(served == '1, "R10 all served", served, '1);
    end

    // random phase on four hot words
    void'($urandom(32'h5EED));
    for (int it = 0; it < 600; it++) begin
      int p = int'($urandom % N);
      logic [1:0] op = 2'($urandom);
      logic [AW-1:0] a = AW'($urandom % 4);
      do_req(p, op, a, $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule